// File: doc/BRIEF.md
# Character Display Fetch Address Sequencer

This block produces the memory address for a tile-based text or graphics display, one fetch per clock. Inside the active window it alternates two kinds of read. On even column cycles it reads a character code from the video matrix. On odd column cycles it reads a bitmap byte from the character cell area, using the code that came back from the previous read. Outside the window it parks the bus on a fixed idle address. The raster counters come from outside, together with a line-start strobe and a field-start strobe.

The window is opened in two steps. A vertical latch arms once per field, when the first-row setting matches the halved vertical count. After that, a horizontal latch opens once per line when the horizontal count reaches the first-column setting. A short per-line start-up sequence then samples the column count on every line and the row count once per field, before column fetching begins. The block also keeps the scanline inside the current character, the current text row and a matrix base pointer. The base pointer only moves on the last scanline of a character, so every scanline of a text row reads the same codes again.

The memory is outside the block. `code_in` must carry the byte stored at the address currently on `addr`, and the block samples it at the next clock edge.

Top module: `fas_fetch_seq`

## Requirements
- R1: While `rst` is high, and on the first output after it, `addr` is 0x1C and `pix_win` is low.
- R2: The vertical latch sets in a cycle where `first_row` equals the `v_cnt` of the previous cycle shifted right by one. The horizontal latch sets when the vertical latch is set and `h_cnt` equals `first_col`. The first matrix fetch belongs to the raster cycle with `h_cnt` equal to `first_col`+3. Every output appears after the clock edge that samples its raster cycle.
- R3: On a drawing line whose text row is below the sampled row count, exactly 2×`n_cols` fetch cycles occur, and `n_cols` is sampled anew on every line. `pix_win` is high on exactly those cycles.
- R4: A matrix fetch (even column) outputs `mtx_base_addr` plus the matrix counter, and the counter then advances by one.
- R5: A cell fetch (odd column) outputs `cell_base_addr` + code×8 + character row, or code×16 when `tall` is 1. The code is the `code_in` value sampled on that cycle's edge.
- R6: Outside the fetch window `addr` is 0x1C. Every address is reduced modulo 2^14.
- R7: On each line that opened the horizontal latch, the character row advances at the next line start. It wraps after 7 (or after 15 when `tall` is 1), and the text row then increments.
- R8: At the start of each drawing line the matrix counter reloads from the base pointer. The base pointer takes the advanced counter only during matrix fetches on the last character row, so codes repeat across the scanlines of a text row.
- R9: `n_rows` is sampled on the third cycle of the first drawing line of a field and is held for the rest of that field. Text rows at or above it produce no fetches.
- R10: A cycle with both `line_start` and `field_start` high clears the text row, the character row, the row-count sample, the vertical latch and the base pointer.
- R11: The output for any raster cycle with `line_start` high has `pix_win` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | High on the first cycle of each raster line (h_cnt = 0) |
| field_start | input | 1 | High with line_start on the first line of a field |
| h_cnt | input | HW | Horizontal raster count |
| v_cnt | input | VW | Vertical raster count |
| first_col | input | HW | Horizontal window start |
| first_row | input | VW-1 | Vertical window start, compared with v_cnt/2 |
| n_cols | input | COLW | Character columns per line |
| n_rows | input | ROWW | Text rows per field |
| tall | input | 1 | 1 selects 16-scanline characters, 0 selects 8 |
| mtx_base_addr | input | AW | Video matrix start address |
| cell_base_addr | input | AW | Character cell area start address |
| code_in | input | CODEW | Byte read from the address currently on addr |
| addr | output | AW | Fetch address |
| pix_win | output | 1 | High while addr is a window fetch |

## Verification
The bench uses the default widths: a 7-bit horizontal count, a 9-bit vertical count, 7-bit column and 6-bit row counts, a 14-bit address and 8-bit codes. It drives a short raster of 24 cycles by 40 lines, so complete fields, text-row changes, row-count cut-off and field restarts all fit in a few thousand cycles. The base addresses are placed near the top of the 14-bit space, which makes both the matrix sum and the cell sum wrap past the address width. Tall characters, a column count that changes from line to line and a row count changed after sampling are also covered.

// File: rtl/fas_pkg.sv
package fas_pkg;

  // per-line start-up phases after the horizontal latch opens
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_0,
    PH_1,
    PH_2,
    PH_3,
    PH_RUN
  } phase_e;

  function automatic phase_e phase_step(input phase_e p);
    case (p)
      PH_0:    return PH_1;
      PH_1:    return PH_2;
      PH_2:    return PH_3;
      default: return PH_RUN;
    endcase
  endfunction

  localparam int CHAR_ROW_W = 4;

endpackage

// File: rtl/fas_start_latch.sv
module fas_start_latch #(
  parameter int HW = 7,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          field_start,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic [HW-1:0] first_col,
  input  logic [VW-2:0] first_row,
  output logic          hlatch_q,
  output logic          hlatch_nx
);

  logic [VW-1:0] prev_v;
  logic          vl_q;
  logic          vl_nx;
  logic          hl_q;

  always_comb begin
    // vertical match uses the count seen one cycle earlier
    vl_nx     = ((line_start && field_start) ? 1'b0 : vl_q)
              | (first_row == prev_v[VW-1:1]);
    hlatch_nx = (line_start ? 1'b0 : hl_q)
              | (vl_nx && (h_cnt == first_col));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_v <= '0;
      vl_q   <= 1'b0;
      hl_q   <= 1'b0;
    end else begin
      prev_v <= v_cnt;
      vl_q   <= vl_nx;
      hl_q   <= hlatch_nx;
    end
  end

  assign hlatch_q = hl_q;

endmodule

// File: rtl/fas_row_track.sv
module fas_row_track
  import fas_pkg::*;
#(
  parameter int TRW = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_start,
  input  logic                  field_start,
  input  logic                  hlatch_q,
  input  logic                  tall,
  output logic [CHAR_ROW_W-1:0] char_row_nx,
  output logic [TRW-1:0]        text_row_nx,
  output logic                  last_row_nx
);

  logic [CHAR_ROW_W-1:0] cr_q;
  logic [TRW-1:0]        tr_q;
  logic                  wrap;

  always_comb begin
    char_row_nx = cr_q;
    text_row_nx = tr_q;
    wrap        = (cr_q == 4'd15) || (!tall && cr_q == 4'd7);
    if (line_start && hlatch_q) begin
      if (wrap) begin
        char_row_nx = '0;
        text_row_nx = tr_q + TRW'(1);
      end else begin
        char_row_nx = cr_q + 4'd1;
      end
    end
    if (line_start && field_start) begin
      char_row_nx = '0;
      text_row_nx = '0;
    end
    last_row_nx = (char_row_nx == 4'd15) || (!tall && char_row_nx == 4'd7);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q <= '0;
      tr_q <= '0;
    end else begin
      cr_q <= char_row_nx;
      tr_q <= text_row_nx;
    end
  end

endmodule

// File: rtl/fas_line_ctrl.sv
module fas_line_ctrl
  import fas_pkg::*;
#(
  parameter int COLW = 7,
  parameter int ROWW = 6,
  parameter int TRW  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start,
  input  logic            field_start,
  input  logic            hlatch_q,
  input  logic            hlatch_nx,
  input  logic [COLW-1:0] n_cols,
  input  logic [ROWW-1:0] n_rows,
  input  logic [TRW-1:0]  text_row_nx,
  output logic            load_mtx,
  output logic            fetch_en,
  output logic            fetch_odd
);

  localparam int CCW = COLW + 1;

  phase_e          ph_q, ph;
  logic [COLW-1:0] cols_q, cols;
  logic [ROWW-1:0] rows_q, rows;
  logic            rows_ok_q, rows_ok;
  logic            cidle_q, cidle;
  logic [CCW-1:0]  col_q, col;

  always_comb begin
    ph       = ph_q;
    cols     = cols_q;
    rows     = rows_q;
    rows_ok  = rows_ok_q;
    cidle    = cidle_q;
    col      = col_q;
    load_mtx = 1'b0;

    // close the previous line's window
    if (line_start && hlatch_q) begin
      ph    = PH_IDLE;
      cols  = '0;
      cidle = 1'b1;
      col   = '0;
    end
    if (line_start && field_start) rows_ok = 1'b0;

    if (ph != PH_IDLE) begin
      ph = phase_step(ph);
    end else if (hlatch_nx) begin
      ph       = PH_0;
      load_mtx = 1'b1;
    end

    if (ph == PH_1) cols = n_cols;
    if (ph == PH_2 && !rows_ok) begin
      rows    = n_rows;
      rows_ok = 1'b1;
    end
    if (ph == PH_3 && (text_row_nx < TRW'(rows))) begin
      cidle = 1'b0;
      col   = '0;
    end

    fetch_en  = !cidle && (col < {cols, 1'b0});
    fetch_odd = col[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cols_q    <= '0;
      rows_q    <= '0;
      rows_ok_q <= 1'b0;
      cidle_q   <= 1'b1;
      col_q     <= '0;
    end else begin
      ph_q      <= ph;
      cols_q    <= cols;
      rows_q    <= rows;
      rows_ok_q <= rows_ok;
      cidle_q   <= cidle;
      col_q     <= fetch_en ? col + CCW'(1) : col;
    end
  end

endmodule

// File: rtl/fas_addr_gen.sv
module fas_addr_gen
  import fas_pkg::*;
#(
  parameter int AW        = 14,
  parameter int CODEW     = 8,
  parameter int IDLE_ADDR = 'h1C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_start,
  input  logic                  field_start,
  input  logic                  load_mtx,
  input  logic                  fetch_en,
  input  logic                  fetch_odd,
  input  logic                  last_row_nx,
  input  logic                  tall,
  input  logic [CHAR_ROW_W-1:0] char_row_nx,
  input  logic [CODEW-1:0]      code_in,
  input  logic [AW-1:0]         mtx_base_addr,
  input  logic [AW-1:0]         cell_base_addr,
  output logic [AW-1:0]         addr_q,
  output logic                  win_q
);

  logic [AW-1:0] base_q, base;
  logic [AW-1:0] cnt_q, cnt;
  logic [AW-1:0] addr;
  logic [AW-1:0] cell_off;

  always_comb begin
    base     = (line_start && field_start) ? '0 : base_q;
    cnt      = load_mtx ? base : cnt_q;
    addr     = AW'(IDLE_ADDR);
    cell_off = tall ? (AW'(code_in) << 4) : (AW'(code_in) << 3);
    if (fetch_en) begin
      if (fetch_odd) begin
        addr = cell_base_addr + cell_off + AW'(char_row_nx);
      end else begin
        addr = mtx_base_addr + cnt;
        cnt  = cnt + AW'(1);
        if (last_row_nx) base = cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      addr_q <= AW'(IDLE_ADDR);
      win_q  <= 1'b0;
    end else begin
      base_q <= base;
      cnt_q  <= cnt;
      addr_q <= addr;
      win_q  <= fetch_en;
    end
  end

endmodule

// File: rtl/fas_fetch_seq.sv
module fas_fetch_seq
  import fas_pkg::*;
#(
  parameter int HW        = 7,
  parameter int VW        = 9,
  parameter int COLW      = 7,
  parameter int ROWW      = 6,
  parameter int AW        = 14,
  parameter int CODEW     = 8,
  parameter int IDLE_ADDR = 'h1C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             field_start,
  input  logic [HW-1:0]    h_cnt,
  input  logic [VW-1:0]    v_cnt,
  input  logic [HW-1:0]    first_col,
  input  logic [VW-2:0]    first_row,
  input  logic [COLW-1:0]  n_cols,
  input  logic [ROWW-1:0]  n_rows,
  input  logic             tall,
  input  logic [AW-1:0]    mtx_base_addr,
  input  logic [AW-1:0]    cell_base_addr,
  input  logic [CODEW-1:0] code_in,
  output logic [AW-1:0]    addr,
  output logic             pix_win
);

  // text row can count every line of a field
  localparam int TRW = VW;

  logic                  hlatch_q, hlatch_nx;
  logic [CHAR_ROW_W-1:0] char_row_nx;
  logic [TRW-1:0]        text_row_nx;
  logic                  last_row_nx;
  logic                  load_mtx, fetch_en, fetch_odd;

  fas_start_latch #(.HW(HW), .VW(VW)) u_latch (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .first_col(first_col), .first_row(first_row),
    .hlatch_q(hlatch_q), .hlatch_nx(hlatch_nx)
  );

  fas_row_track #(.TRW(TRW)) u_rows (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .hlatch_q(hlatch_q), .tall(tall), .char_row_nx(char_row_nx),
    .text_row_nx(text_row_nx), .last_row_nx(last_row_nx)
  );

  fas_line_ctrl #(.COLW(COLW), .ROWW(ROWW), .TRW(TRW)) u_line (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .hlatch_q(hlatch_q), .hlatch_nx(hlatch_nx), .n_cols(n_cols), .n_rows(n_rows),
    .text_row_nx(text_row_nx), .load_mtx(load_mtx), .fetch_en(fetch_en),
    .fetch_odd(fetch_odd)
  );

  fas_addr_gen #(.AW(AW), .CODEW(CODEW), .IDLE_ADDR(IDLE_ADDR)) u_addr (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .load_mtx(load_mtx), .fetch_en(fetch_en), .fetch_odd(fetch_odd),
    .last_row_nx(last_row_nx), .tall(tall), .char_row_nx(char_row_nx),
    .code_in(code_in), .mtx_base_addr(mtx_base_addr),
    .cell_base_addr(cell_base_addr), .addr_q(addr), .win_q(pix_win)
  );

endmodule

// File: rtl/fas_fetch_seq_chk.sv
module fas_fetch_seq_chk #(
  parameter int AW        = 14,
  parameter int IDLE_ADDR = 'h1C
) (
  input logic          clk,
  input logic          rst,
  input logic          line_start,
  input logic [AW-1:0] addr,
  input logic          pix_win
);

  logic          par_q;
  logic          m_valid_q;
  logic [AW-1:0] m_last_q;

  // track window position parity and the last matrix address seen
  always_ff @(posedge clk) begin
    if (rst || !pix_win) begin
      par_q     <= 1'b0;
      m_valid_q <= 1'b0;
      m_last_q  <= '0;
    end else begin
      par_q <= ~par_q;
      if (!par_q) begin
        m_valid_q <= 1'b1;
        m_last_q  <= addr;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!pix_win && addr == AW'(IDLE_ADDR))); // R1

  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
    !pix_win |-> addr == AW'(IDLE_ADDR)); // R6

  AST_LINE_CLOSE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !pix_win); // R11

  AST_MATRIX_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_win && !par_q && m_valid_q) |-> addr == m_last_q + AW'(1)); // R4

endmodule

bind fas_fetch_seq fas_fetch_seq_chk #(.AW(AW), .IDLE_ADDR(IDLE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .addr(addr), .pix_win(pix_win)
);

// File: tb/test_fas_fetch_seq.sv
module test_fas_fetch_seq;
  localparam int HW = 7, VW = 9, COLW = 7, ROWW = 6, AW = 14, CODEW = 8;
  localparam int HL = 24, VL = 40;
  localparam int IDLE = 'h1C;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, line_start, field_start, tall;
  logic [HW-1:0]    h_cnt, first_col;
  logic [VW-1:0]    v_cnt;
  logic [VW-2:0]    first_row;
  logic [COLW-1:0]  n_cols;
  logic [ROWW-1:0]  n_rows;
  logic [AW-1:0]    mtx_base_addr, cell_base_addr, addr;
  logic [CODEW-1:0] code_in;
  logic             pix_win;

  function automatic int code_of(input int a);
    return (a * 7 + 3) & 8'hFF;
  endfunction

  assign code_in = CODEW'(code_of(int'(addr)));

  fas_fetch_seq i_fas_fetch_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .first_col(first_col), .first_row(first_row),
    .n_cols(n_cols), .n_rows(n_rows), .tall(tall), .mtx_base_addr(mtx_base_addr),
    .cell_base_addr(cell_base_addr), .code_in(code_in), .addr(addr), .pix_win(pix_win)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // scenario knobs and expectation state
  int s_R, s_C, s_cols, s_rows, s_tall, s_mb, s_cb, s_vary, s_late;
  int e_mbase, e_mcnt, e_rows_s, e_prev;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic apply_knobs();
    first_row      = (VW-1)'(s_R);
    first_col      = HW'(s_C);
    n_cols         = COLW'(s_cols);
    n_rows         = ROWW'(s_rows);
    tall           = s_tall[0];
    mtx_base_addr  = AW'(s_mb);
    cell_base_addr = AW'(s_cb);
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; line_start = 1'b0; field_start = 1'b0; h_cnt = '0; v_cnt = '0;
    apply_knobs();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "addr", int'(addr), IDLE);
    chk("R1", "pix_win", int'(pix_win), 0);
    @(negedge clk);
    rst = 1'b0;
    e_prev = IDLE;
  endtask

  task automatic run_field(input int fld);
    int L0, rh;
    L0 = (s_C >= 1) ? 2 * s_R : 2 * s_R + 1;
    rh = s_tall ? 16 : 8;
    for (int v = 0; v < VL; v++) begin
      int winc, dl, cr, t;
      winc = 0;
      dl = v - L0;
      cr = (v >= L0) ? dl % rh : 0;
      t  = (v >= L0) ? dl / rh : 0;
      for (int h = 0; h < HL; h++) begin
        int k, ex, code;
        bit pos, inwin;
        string tag;
        if (h != 0) @(negedge clk);
        else if (!(v == 0 && fld == 0)) @(negedge clk);
        else @(negedge clk);
        h_cnt = HW'(h); v_cnt = VW'(v);
        line_start = (h == 0);
        field_start = (h == 0 && v == 0);
        if (h == 0) begin
          if (s_vary != 0) n_cols = COLW'(1 + (v % 4));
          if (s_late >= 0 && v == L0 + 1) n_rows = ROWW'(s_late);
          if (v == 0) begin e_mbase = 0; e_rows_s = 0; end
          e_mcnt = e_mbase;
        end
        if (v == L0 && h == s_C + 2) e_rows_s = int'(n_rows);
        k = h - (s_C + 3);
        pos = (v >= L0) && (k >= 0) && (k < 2 * int'(n_cols));
        inwin = pos && (t < e_rows_s);
        ex = IDLE;
        if (inwin) begin
          if (k % 2 == 0) begin
            ex = (s_mb + e_mcnt) & MASK;
            e_mcnt++;
            if (cr == rh - 1) e_mbase = e_mcnt;
          end else begin
            code = code_of(e_prev);
            ex = (s_cb + code * rh + cr) & MASK;
          end
        end
        if (h == 0) tag = "R11";
        else if (inwin) begin
          if (k == 0) tag = (v == L0) ? ((fld == 0) ? "R2" : "R10") : "R8";
          else if (k == 1) tag = "R7";
          else tag = (k % 2 == 1) ? "R5" : "R4";
        end else if (pos) tag = "R9";
        else tag = "R6";
        @(posedge clk);
        #1;
        chk(tag, "addr", int'(addr), ex);
        chk(tag, "pix_win", int'(pix_win), int'(inwin));
        e_prev = ex;
        if (pix_win) winc++;
        if (h == HL - 1)
          chk("R3", "window length",
              winc, (v >= L0 && t < e_rows_s) ? 2 * int'(n_cols) : 0);
      end
    end
  endtask

  // R2 R4 R5 R6 R7 R8 R9: short characters, three text rows
  task automatic t_short();
    s_R = 1; s_C = 2; s_cols = 5; s_rows = 3; s_tall = 0;
    s_mb = 'h1000; s_cb = 'h2000; s_vary = 0; s_late = -1;
    t_reset();
    run_field(0);
  endtask

  // R5 R6 R7: tall characters, both sums wrap past 14 bits
  task automatic t_tall_wrap();
    s_R = 2; s_C = 1; s_cols = 4; s_rows = 2; s_tall = 1;
    s_mb = 'h3FFE; s_cb = 'h3C00; s_vary = 0; s_late = -1;
    t_reset();
    run_field(0);
  endtask

  // R3 R9 R10: per-line column count, late row-count change, second field
  task automatic t_fields();
    s_R = 1; s_C = 4; s_cols = 1; s_rows = 4; s_tall = 0;
    s_mb = 'h0200; s_cb = 'h0800; s_vary = 1; s_late = 1;
    t_reset();
    run_field(0);
    run_field(1);
  endtask

  initial begin
    rst = 1'b1; line_start = 1'b0; field_start = 1'b0;
    h_cnt = '0; v_cnt = '0;
    s_R = 1; s_C = 2; s_cols = 1; s_rows = 1; s_tall = 0;
    s_mb = 0; s_cb = 0; s_vary = 0; s_late = -1;
    apply_knobs();
    t_short();
    t_tall_wrap();
    t_fields();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule